// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog whose 7-bit counter must be reloaded inside a time window rather than merely before it runs out. The bus clock feeds a fixed power-of-two divider of 2^DIV_W cycles and then a selectable prescaler of 1, 2, 4 or 8. Each resulting tick decrements the counter by one. Software restarts the count with a control write and sets the window edge and the prescaler through a configuration write.

A one-cycle reset request is raised in three cases: the counter falls from 0x40 to 0x3F, software reloads while the counter is still above the window value, or software writes a counter value whose bit 6 is clear. Nothing is requested until an activation bit has been set, and that bit can only be cleared by the block's own reset. A debug-halt input stops the count when the freeze option is selected.

The tick period is 2^(DIV_W+sel) bus clock cycles. The time to expiry is therefore that period times (counter bits [5:0] + 1).

Top module: `wwdg_timer`

## Requirements
- R1: After rst_ni is released, cnt_o reads 0x7F, rst_req_o is low, the watchdog is inactive, the window value is 0x7F and the prescaler select is 0.
- R2: A control write loads ctrl_wdata_i[6:0] into the counter. It sets activation when ctrl_wdata_i[7] is 1. Once set, activation stays set until rst_ni, and a later write with bit 7 at 0 does not clear it.
- R3: A configuration write takes the window value from cfg_wdata_i[6:0] and the prescaler select from cfg_wdata_i[8:7]. Both are used from the next cycle on.
- R4: While active and not frozen, the counter decrements by one every 2^(DIV_W+sel) clock cycles, where sel is the prescaler select. The count wraps modulo 128.
- R5: While inactive, the counter and the prescaler hold their values, control writes still load the counter, and rst_req_o stays low whatever is written.
- R6: While active, the decrement from 0x40 to 0x3F raises rst_req_o in the cycle after the clock edge that performs it.
- R7: While active, a control write raises rst_req_o one cycle later if the counter is greater than the window value when the write is taken. A write at or below the window raises nothing.
- R8: A control write with bit 6 at 0 raises rst_req_o one cycle later when the watchdog is active or the same write sets activation.
- R9: Every control write restarts the prescaler. The first decrement after a write comes exactly 2^(DIV_W+sel) cycles after it.
- R10: With dbg_halt_i and dbg_freeze_i both high, the counter and prescaler hold. With dbg_freeze_i low, a debug halt has no effect on the count.
- R11: rst_req_o is registered and stays high for exactly one cycle per triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | [7] activate, [6:0] counter load value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | [8:7] prescaler select, [6:0] window value |
| dbg_halt_i | input | 1 | Processor halted in debug |
| dbg_freeze_i | input | 1 | Stop the count while halted in debug |
| cnt_o | output | 7 | Current counter value |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong prescaler phase shows up as a decrement of cnt_o one or more cycles away from the expected edge. It appears at the first tick after the faulty write, within 2^(DIV_W+sel) cycles. A wrong counter value or window comparison shows up as a missing, early or extra rst_req_o pulse at the threshold crossing or at a reload. A lost activation bit silences the count entirely and is visible within one tick. Comparing a behavioural model against cnt_o and rst_req_o on every cycle catches all of these at the cycle where they first differ.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  localparam int CNT_W = 7;
  localparam int SEL_W = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic act;
    cnt_t val;
  } ctrl_t;

  typedef struct packed {
    sel_t sel;
    cnt_t win;
  } cfg_t;

  localparam cnt_t CNT_RST = '1;
  localparam cnt_t CNT_THR = cnt_t'(1) << (CNT_W - 1);
endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler
  import wwdg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  sel_t sel_i,
  output logic tick_o
);
  localparam int NSEL = 1 << SEL_W;
  localparam int PC_W = DIV_W + NSEL - 1;

  logic [PC_W-1:0] pc_q;
  logic [NSEL-1:0] wrap;

  // one terminal-count detector per prescaler setting
  for (genvar g = 0; g < NSEL; g++) begin : g_wrap
    assign wrap[g] = &pc_q[DIV_W+g-1:0];
  end

  assign tick_o = run_i & wrap[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (restart_i) pc_q <= '0;
    else if (run_i)     pc_q <= pc_q + 1'b1;
  end

  a_r10_prescale_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(pc_q));
  a_r9_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pc_q == '0));
endmodule

// File: rtl/wwdg_downcnt.sv
module wwdg_downcnt
  import wwdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cnt_t load_val_i,
  input  logic tick_i,
  output cnt_t cnt_o,
  output logic cross_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  // threshold crossing: this tick clears the MSB
  assign cross_o = tick_i & ~load_i & (cnt_q == CNT_THR);

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == cnt_t'($past(cnt_q) - 1'b1)));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  a_r6_cross_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cross_o |=> (cnt_q[CNT_W-1] == 1'b0));
endmodule

// File: rtl/wwdg_guard.sv
module wwdg_guard
  import wwdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic load_i,
  input  logic act_bit_i,
  input  cnt_t load_val_i,
  input  cnt_t cnt_i,
  input  cnt_t win_i,
  input  logic cross_i,
  output logic rst_req_o
);
  logic early, bad_val, expire, event_d, rst_q;

  assign early   = active_i & load_i & (cnt_i > win_i);
  assign bad_val = load_i & (active_i | act_bit_i) & ~load_val_i[CNT_W-1];
  assign expire  = active_i & cross_i;
  assign event_d = early | bad_val | expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= event_d;
  end

  assign rst_req_o = rst_q;

  a_r7_early_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && load_i && cnt_i > win_i) |=> rst_req_o);
  a_r8_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && act_bit_i && !load_val_i[CNT_W-1]) |=> rst_req_o);
  a_r6_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cross_i) |=> rst_req_o);
endmodule

// File: rtl/wwdg_timer.sv
module wwdg_timer
  import wwdg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       cfg_we_i,
  input  logic [8:0] cfg_wdata_i,
  input  logic       dbg_halt_i,
  input  logic       dbg_freeze_i,
  output logic [6:0] cnt_o,
  output logic       rst_req_o
);
  ctrl_t ctrl;
  cfg_t  cfg;
  logic  active_q;
  cnt_t  win_q;
  sel_t  sel_q;
  logic  run, tick_w, cross_w;
  cnt_t  cnt_w;

  assign ctrl = ctrl_t'(ctrl_wdata_i);
  assign cfg  = cfg_t'(cfg_wdata_i);
  assign run  = active_q & ~(dbg_halt_i & dbg_freeze_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      active_q <= 1'b0;
    else if (ctrl_we_i && ctrl.act)   active_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= CNT_RST;
      sel_q <= '0;
    end else if (cfg_we_i) begin
      win_q <= cfg.win;
      sel_q <= cfg.sel;
    end
  end

  wwdg_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (ctrl_we_i),
    .sel_i     (sel_q),
    .tick_o    (tick_w)
  );

  wwdg_downcnt u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_we_i),
    .load_val_i (ctrl.val),
    .tick_i     (tick_w),
    .cnt_o      (cnt_w),
    .cross_o    (cross_w)
  );

  wwdg_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active_q),
    .load_i     (ctrl_we_i),
    .act_bit_i  (ctrl.act),
    .load_val_i (ctrl.val),
    .cnt_i      (cnt_w),
    .win_i      (win_q),
    .cross_i    (cross_w),
    .rst_req_o  (rst_req_o)
  );

  assign cnt_o = cnt_w;

  a_r2_sticky_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q);
  a_r5_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !(ctrl_we_i && ctrl.act)) |=> !rst_req_o);
  a_r9_no_tick_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !tick_w);
  a_r10_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i && dbg_freeze_i && !ctrl_we_i) |=> $stable(cnt_o));
endmodule

// File: tb/sim_wwdg_timer.sv
`timescale 1ns/1ps
module sim_wwdg_timer;
  localparam int DIV_W = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_d = '0;
  logic       cfg_we = 1'b0;
  logic [8:0] cfg_d = '0;
  logic       halt = 1'b0;
  logic       frz = 1'b0;
  logic [6:0] cnt;
  logic       rreq;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt = 127, m_win = 127, m_sel = 0, m_pc = 0;
  bit m_act = 0, m_rst = 0;

  always #4 clk = ~clk;

  wwdg_timer #(.DIV_W(DIV_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_d),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_d), .dbg_halt_i(halt),
    .dbg_freeze_i(frz), .cnt_o(cnt), .rst_req_o(rreq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 127; m_win = 127; m_sel = 0; m_pc = 0; m_act = 0; m_rst = 0;
    end else begin
      bit run, tick, ev, en;
      int per;
      per  = 1 << (DIV_W + m_sel);
      run  = m_act && !(halt && frz);
      tick = run && ((m_pc % per) == per - 1);
      ev   = 0;
      if (ctrl_we) begin
        en = m_act || ctrl_d[7];
        if (m_act && m_cnt > m_win) ev = 1;
        if (en && !ctrl_d[6]) ev = 1;
        m_cnt = ctrl_d[6:0];
        m_pc  = 0;
        m_act = en;
      end else begin
        if (tick) begin
          if (m_act && m_cnt == 64) ev = 1;
          m_cnt = (m_cnt + 127) % 128;
        end
        if (run) m_pc = m_pc + 1;
      end
      if (cfg_we) begin
        m_win = cfg_d[6:0];
        m_sel = cfg_d[8:7];
      end
      m_rst = ev;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (cnt != 7'(m_cnt) || rreq != m_rst) begin
        fails++;
        $display("FAIL %s cycle compare: cnt=%h rst_req=%b expected cnt=%h rst_req=%b",
                 cur_req, cnt, rreq, 7'(m_cnt), m_rst);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl_wr(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_d = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [6:0] w);
    cfg_we = 1'b1; cfg_d = {s, w};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R1";
    chk("R1 reset cnt", cnt, 'h7F);
    chk("R1 reset rst_req", rreq, 0);

    cur_req = "R5";
    idle(50);
    chk("R5 inactive hold", cnt, 'h7F);
    ctrl_wr(8'h12);                 // bit6 clear, inactive
    chk("R5 no request while inactive", rreq, 0);
    chk("R5 load while inactive", cnt, 'h12);
    idle(20);
    chk("R5 inactive counter hold", cnt, 'h12);

    cur_req = "R9";
    ctrl_wr(8'hFF);                 // activate, 0x7F
    idle(40);
    chk("R9 R4 ten ticks after write", cnt, 'h75);

    cur_req = "R6";
    for (int i = 0; i < 400 && !rreq; i++) @(negedge clk);
    chk("R6 timeout request", rreq, 1);
    chk("R6 counter at 0x3F", cnt, 'h3F);
    idle(1);
    chk("R11 one cycle pulse", rreq, 0);

    cur_req = "R7";
    cfg_wr(2'd0, 7'h50);
    ctrl_wr(8'hFF);                 // counter below window: allowed
    chk("R7 reload inside window", rreq, 0);
    ctrl_wr(8'hFF);                 // 0x7F > 0x50: violation
    chk("R7 early reload", rreq, 1);
    for (int i = 0; i < 400 && cnt != 7'h50; i++) @(negedge clk);
    chk("R7 reached window edge", cnt, 'h50);
    ctrl_wr(8'hFF);
    chk("R7 reload at window edge", rreq, 0);

    cur_req = "R8";
    cfg_wr(2'd0, 7'h7F);
    ctrl_wr(8'hA0);
    chk("R8 bit6 clear request", rreq, 1);
    ctrl_wr(8'hFF);
    chk("R8 clean reload", rreq, 0);

    cur_req = "R2";
    ctrl_wr(8'h7F);                 // act bit 0: stays active
    idle(8);
    chk("R2 activation sticky", cnt, 'h7D);

    cur_req = "R10";
    halt = 1'b1; frz = 1'b1;
    idle(40);
    chk("R10 frozen hold", cnt, 'h7D);
    frz = 1'b0;
    idle(40);
    chk("R10 halt without freeze runs", cnt, 'h73);
    halt = 1'b0;

    cur_req = "R3";
    cfg_wr(2'd3, 7'h7F);
    ctrl_wr(8'hFF);
    idle(96);
    chk("R3 R4 select 3 period", cnt, 'h7C);
    cfg_wr(2'd1, 7'h7F);
    ctrl_wr(8'hFF);
    idle(40);
    chk("R3 R4 select 1 period", cnt, 'h7A);
    idle(3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule